// File: doc/BRIEF.md
# Edge-Timed Serial Line Bit Demodulator

This block recovers data bits from a single serial input that carries Manchester, biphase-mark or pulse-width coding. An interval counter advances on a clock-enable tick, which can come from any internal prescaler. Qualified edges on the line restart the counter. When the count reaches a programmable compare value, the block takes one bit decision. That decision shifts into an 8-bit register, most significant bit first.

Decoding does not start as soon as the block is armed. The block first waits until it has seen a full bit period between two qualified edges. This aligns the compare point with the bit cells. After that, the compare match is the shift clock. It is also brought out as a pulse that another timer can use. If the line stops toggling, the block drops back to waiting for a new alignment and discards the partial byte.

The compare value is normally set to about three quarters of a bit period, in ticks. Edges that arrive before the match are cell-boundary edges or biphase mid-cell edges. Edges that arrive after the match restart timing.

Top module: `coded_line_demod`

## Requirements
- R1: After reset, the shift register output is 0 and the byte-ready, shift and compare-match pulses are all low.
- R2: No bit is shifted unless `arm` is high and the block has locked. Locking needs a first qualified edge, then a second qualified edge that follows it by at least `cmp_val` ticks and fewer than 2*`cmp_val` ticks. A line whose edges are only half a bit period apart never locks. While `arm` is low, nothing is shifted.
- R3: The interval counter advances only on clock cycles where `tick` is high. With `tick` held low the block never locks. Decoding works the same at any tick rate when the timing is expressed in ticks.
- R4: Mode 0 (Manchester) shifts in the synchronised line level present at the compare match, `cmp_val` ticks after the restarting edge. A bit cell whose first half is high encodes 1. Edges before the match (cell-boundary edges) are ignored.
- R5: Mode 1 (biphase). Every cell starts with a transition, and an extra mid-cell transition encodes 1. A toggle flop is cleared at each frame-start edge and flips on each qualified edge before the match. Its value, not the line, is shifted in.
- R6: Mode 2 (pulse width). With only rising edges enabled, each rising edge restarts timing, and the line level at the following compare match is the bit. A high time longer than the compare point encodes 1.
- R7: `edge_en[0]` enables rising edges and `edge_en[1]` enables falling edges. A disabled edge polarity neither restarts timing nor toggles the biphase flop. With both bits 0 the block never locks.
- R8: Bits enter at bit 0 and move toward bit 7, so the first bit received ends in bit 7. `byte_rdy` is high for exactly one cycle on every eighth shift, and `data_o` holds the completed byte in that same cycle.
- R9: Each compare match produces exactly one `shift_stb` pulse and one `match_pulse`, in the same cycle. Shifts occur only while locked.
- R10: If no restarting edge arrives within 2*`cmp_val` ticks of the last restart, the block stops decoding and clears the partial bit count. It then waits for a new lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_in | input | 1 | Coded serial line (asynchronous, synchronised inside) |
| tick | input | 1 | Counter clock enable from a prescaler |
| arm | input | 1 | High to decode; low returns the block to idle |
| mode | input | 2 | 0 Manchester, 1 biphase, 2 pulse width, 3 reserved (decoded as Manchester) |
| edge_en | input | 2 | Bit 0 enables rising edges, bit 1 enables falling edges |
| cmp_val | input | CNT_W | Compare point in ticks after the restarting edge (at least 2) |
| data_o | output | DW | Shift register contents |
| byte_rdy | output | 1 | One-cycle pulse when a full byte has been shifted |
| shift_stb | output | 1 | One-cycle pulse per shifted bit |
| match_pulse | output | 1 | One-cycle compare-match pulse for use by another timer |

## Verification
- **Repeated Manchester bits.** The bench sends bytes with runs of equal bits, so cell-boundary edges appear. A design that restarted on those edges would slip its sampling point and return a wrong byte.
- **Lock condition.** A stream of all ones has only half-period intervals and must never lock. A design that locked on any interval would shift out garbage.
- **Timeout recovery.** A partial byte is followed by a gap and then a fresh byte. A design that kept the stale bit count would raise `byte_rdy` early, with misaligned data.
- **Pulse-width mode.** Falling edges must stay out of the timing. If they restarted it, extra decisions would be taken.
- **Tick rates.** Decoding is checked at two tick rates, and with the tick held low.

// File: rtl/bitdemod_pkg.sv
// Shared encodings for the serial line bit demodulator.
package bitdemod_pkg;

    // Line coding selected by the mode input
    typedef enum logic [1:0] {
        MODE_MAN = 2'd0,
        MODE_BIP = 2'd1,
        MODE_PWM = 2'd2,
        MODE_RSV = 2'd3
    } mode_e;

    // Interval timer states
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SYNC = 2'd1,
        ST_RUN  = 2'd2
    } tstate_e;

endpackage

// File: rtl/bd_edge_unit.sv
// Synchronises the asynchronous line into the clock domain and flags
// qualified edges.
// Assumes: line_i may change at any time; edge_en_i is quasi-static.
module bd_edge_unit #(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       line_i,
    input  logic [1:0] edge_en_i,
    output logic       level_o,
    output logic       edge_o
);

    logic [SYNC_STAGES:0] pipe;
    logic                 rise;
    logic                 fall;

    // Synchroniser chain plus one history stage for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe <= '0;
        end else begin
            pipe <= {pipe[SYNC_STAGES-1:0], line_i};
        end
    end

    // Decode edge polarity and apply the enables
    always_comb begin
        level_o = pipe[SYNC_STAGES-1];
        rise    = pipe[SYNC_STAGES-1] & ~pipe[SYNC_STAGES];
        fall    = ~pipe[SYNC_STAGES-1] & pipe[SYNC_STAGES];
        edge_o  = (rise & edge_en_i[0]) | (fall & edge_en_i[1]);
    end

    // R7: with falling edges disabled, a qualified edge leaves the line high
    p_edge_pol_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_o && !edge_en_i[1]) |-> level_o);

endmodule

// File: rtl/bd_interval_timer.sv
// Counts ticks between qualified edges. It locks onto the bit stream after
// a full-period interval, then issues one compare hit per frame and times
// out when the edges stop.
// Assumes: cmp_i >= 2 and cmp_i stays stable while arm_i is high.
module bd_interval_timer
    import bitdemod_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             arm_i,
    input  logic [CNT_W-1:0] cmp_i,
    input  logic             edge_i,
    output logic             hit_o,
    output logic             frame_o,
    output logic             window_o,
    output logic             run_o
);

    localparam int LW = CNT_W + 1;

    tstate_e       state;
    logic [LW-1:0] cnt;
    logic [LW-1:0] cnt_inc;
    logic [LW-1:0] cmp_x;
    logic [LW-1:0] lim;
    logic          matched;
    logic          seen;
    logic          in_run;
    logic          restart;
    logic          expire;
    logic          lock;

    // Next-count, thresholds and event decode
    always_comb begin
        cnt_inc  = cnt + LW'(1);
        cmp_x    = {1'b0, cmp_i};
        lim      = {cmp_i, 1'b0};
        in_run   = (state == ST_RUN);
        restart  = in_run && edge_i && matched;
        hit_o    = in_run && !restart && tick_i && !matched && (cnt_inc == cmp_x);
        expire   = in_run && !restart && !hit_o && tick_i && (cnt_inc >= lim);
        lock     = (state == ST_SYNC) && edge_i && seen && (cnt >= cmp_x) && (cnt < lim);
        frame_o  = restart | lock;
        window_o = in_run && !matched;
        run_o    = in_run;
    end

    // Lock, run and timeout sequencing with the tick-driven counter
    always_ff @(posedge clk) begin
        if (!rst_n || !arm_i) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            matched <= 1'b0;
            seen    <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    state <= ST_SYNC;
                    cnt   <= '0;
                    seen  <= 1'b0;
                end
                ST_SYNC: begin
                    if (edge_i) begin
                        cnt  <= '0;
                        seen <= 1'b1;
                        if (lock) begin
                            state   <= ST_RUN;
                            matched <= 1'b0;
                        end
                    end else if (tick_i && (cnt < lim)) begin
                        cnt <= cnt_inc;
                    end
                end
                ST_RUN: begin
                    if (restart) begin
                        cnt     <= '0;
                        matched <= 1'b0;
                    end else if (hit_o) begin
                        matched <= 1'b1;
                        cnt     <= cnt_inc;
                    end else if (expire) begin
                        state   <= ST_SYNC;
                        cnt     <= '0;
                        matched <= 1'b0;
                        seen    <= 1'b0;
                    end else if (tick_i) begin
                        cnt <= cnt_inc;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R2: the run state is only ever entered from the lock search
    p_lock_from_sync_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && $past(state) != ST_RUN) |-> $past(state) == ST_SYNC);

    // R10: while decoding, the counter never passes the timeout limit
    p_run_cnt_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && cmp_i >= 2) |-> (cnt < lim));

endmodule

// File: rtl/bd_bit_assembler.sv
// Forms each bit decision (line level, or the biphase toggle flop), shifts
// it in most-significant-first and raises the strobes.
// Assumes: hit_i is a single-cycle pulse at most once per frame.
module bd_bit_assembler
    import bitdemod_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    mode_i,
    input  logic          level_i,
    input  logic          edge_i,
    input  logic          window_i,
    input  logic          frame_i,
    input  logic          hit_i,
    input  logic          run_i,
    output logic [DW-1:0] data_o,
    output logic          byte_rdy_o,
    output logic          shift_stb_o,
    output logic          match_o
);

    localparam int              BCW  = $clog2(DW);
    localparam logic [BCW-1:0]  LAST = BCW'(DW - 1);

    logic           tff;
    logic           flip;
    logic           bit_val;
    logic [BCW-1:0] bitcnt;
    logic [DW-1:0]  sr;

    // Pick the decision source for the current mode
    always_comb begin
        flip    = (mode_i == MODE_BIP) && edge_i && window_i;
        bit_val = (mode_i == MODE_BIP) ? (tff ^ flip) : level_i;
        data_o  = sr;
    end

    // Biphase toggle flop: cleared at frame start, flipped by in-window edges
    always_ff @(posedge clk) begin
        if (!rst_n || frame_i) begin
            tff <= 1'b0;
        end else if (flip) begin
            tff <= ~tff;
        end
    end

    // Shift register and bit counter; the partial count drops when not locked
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr     <= '0;
            bitcnt <= '0;
        end else if (hit_i) begin
            sr     <= {sr[DW-2:0], bit_val};
            bitcnt <= (bitcnt == LAST) ? '0 : bitcnt + 1'b1;
        end else if (!run_i) begin
            bitcnt <= '0;
        end
    end

    // Registered strobes aligned with the shift register update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shift_stb_o <= 1'b0;
            match_o     <= 1'b0;
            byte_rdy_o  <= 1'b0;
        end else begin
            shift_stb_o <= hit_i;
            match_o     <= hit_i;
            byte_rdy_o  <= hit_i && (bitcnt == LAST);
        end
    end

    // R8: byte-ready is a single-cycle pulse
    p_byte_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        byte_rdy_o |=> !byte_rdy_o);

    // R8: byte-ready only accompanies a shift
    p_byte_on_shift_r8: assert property (@(posedge clk) disable iff (!rst_n)
        byte_rdy_o |-> shift_stb_o);

    // R9: shifts only follow a cycle in which the timer was locked
    p_shift_in_run_r9: assert property (@(posedge clk) disable iff (!rst_n)
        shift_stb_o |-> $past(run_i));

endmodule

// File: rtl/coded_line_demod.sv
// Top level: edge unit -> interval timer -> bit assembler.
// Assumes: the caller sets cmp_val to about three quarters of a bit period,
// in ticks, and programs edge_en to suit the selected coding.
module coded_line_demod #(
    parameter int CNT_W       = 8,
    parameter int DW          = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_in,
    input  logic             tick,
    input  logic             arm,
    input  logic [1:0]       mode,
    input  logic [1:0]       edge_en,
    input  logic [CNT_W-1:0] cmp_val,
    output logic [DW-1:0]    data_o,
    output logic             byte_rdy,
    output logic             shift_stb,
    output logic             match_pulse
);

    logic level_s;
    logic edge_s;
    logic hit_s;
    logic frame_s;
    logic window_s;
    logic run_s;

    bd_edge_unit #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_i    (line_in),
        .edge_en_i (edge_en),
        .level_o   (level_s),
        .edge_o    (edge_s)
    );

    bd_interval_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (tick),
        .arm_i    (arm),
        .cmp_i    (cmp_val),
        .edge_i   (edge_s),
        .hit_o    (hit_s),
        .frame_o  (frame_s),
        .window_o (window_s),
        .run_o    (run_s)
    );

    bd_bit_assembler #(.DW(DW)) u_asm (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_i      (mode),
        .level_i     (level_s),
        .edge_i      (edge_s),
        .window_i    (window_s),
        .frame_i     (frame_s),
        .hit_i       (hit_s),
        .run_i       (run_s),
        .data_o      (data_o),
        .byte_rdy_o  (byte_rdy),
        .shift_stb_o (shift_stb),
        .match_o     (match_pulse)
    );

endmodule

// File: tb/tb_coded_line_demod.sv
module tb_coded_line_demod;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       line_in;
    logic       tick;
    logic       arm;
    logic [1:0] mode;
    logic [1:0] edge_en;
    logic [7:0] cmp_val;
    logic [7:0] data_o;
    logic       byte_rdy;
    logic       shift_stb;
    logic       match_pulse;

    int n_chk = 0;
    int n_bad = 0;
    int tick_div = 1;
    int nshift, nmatch, nbyte;
    logic [7:0] last_byte;

    always #4 clk = ~clk;

    coded_line_demod dut (
        .clk(clk), .rst_n(rst_n), .line_in(line_in), .tick(tick), .arm(arm),
        .mode(mode), .edge_en(edge_en), .cmp_val(cmp_val), .data_o(data_o),
        .byte_rdy(byte_rdy), .shift_stb(shift_stb), .match_pulse(match_pulse)
    );

    // Tick generator: one tick every tick_div clocks, none when tick_div is 0
    initial begin
        int ph;
        ph = 0;
        tick = 1'b0;
        forever begin
            @(negedge clk);
            if (tick_div == 0) begin
                tick = 1'b0;
            end else begin
                tick = (ph == 0);
                ph = (ph + 1 >= tick_div) ? 0 : ph + 1;
            end
        end
    end

    // Output monitor, sampled away from the active edge
    initial begin
        nshift = 0; nmatch = 0; nbyte = 0; last_byte = '0;
        forever begin
            @(negedge clk);
            if (shift_stb === 1'b1) nshift++;
            if (match_pulse === 1'b1) nmatch++;
            if (byte_rdy === 1'b1) begin
                nbyte++;
                last_byte = data_o;
            end
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic start(input logic [1:0] m, input logic [1:0] en);
        arm = 1'b0;
        line_in = 1'b0;
        wait_clk(6);
        mode = m;
        edge_en = en;
        nshift = 0; nmatch = 0; nbyte = 0; last_byte = '0;
        arm = 1'b1;
        wait_clk(4);
    endtask

    task automatic stop();
        arm = 1'b0;
        wait_clk(4);
    endtask

    task automatic man_bit(input logic v, input int half);
        line_in = v;
        wait_clk(half);
        line_in = ~v;
        wait_clk(half);
    endtask

    task automatic man_pre(input int half);
        man_bit(1'b1, half);
        man_bit(1'b0, half);
    endtask

    task automatic man_data(input logic [7:0] b, input int half);
        for (int i = 7; i >= 0; i--) man_bit(b[i], half);
    endtask

    // R4, R8, R9 (and R3 when div > 1): one Manchester byte
    task automatic t_man(input logic [7:0] b, input int div, input string tag);
        tick_div = div;
        start(2'd0, 2'b11);
        man_pre(8 * div);
        man_data(b, 8 * div);
        wait_clk(48 * div);
        check({tag, " byte count"}, nbyte, 1);
        check({tag, " byte value R8"}, int'(last_byte), int'(b));
        check("R9 shift count", nshift, 9);
        check("R9 match count", nmatch, 9);
        stop();
        tick_div = 1;
    endtask

    // R5: biphase-mark byte
    task automatic t_bip(input logic [7:0] b);
        logic lv;
        start(2'd1, 2'b11);
        lv = 1'b0;
        lv = ~lv; line_in = lv; wait_clk(16);
        for (int i = 7; i >= 0; i--) begin
            lv = ~lv; line_in = lv; wait_clk(8);
            if (b[i]) begin lv = ~lv; line_in = lv; end
            wait_clk(8);
        end
        wait_clk(48);
        check("R5 byte count", nbyte, 1);
        check("R5 byte value", int'(last_byte), int'(b));
        check("R5 shift count", nshift, 8);
        stop();
    endtask

    task automatic pw_bit(input logic v);
        line_in = 1'b1;
        wait_clk(v ? 15 : 5);
        line_in = 1'b0;
        wait_clk(v ? 5 : 15);
    endtask

    // R6, R7: pulse width with rising edges only
    task automatic t_pw(input logic [7:0] b);
        start(2'd2, 2'b01);
        pw_bit(1'b0);
        for (int i = 7; i >= 0; i--) pw_bit(b[i]);
        wait_clk(48);
        check("R6 byte count", nbyte, 1);
        check("R6 byte value", int'(last_byte), int'(b));
        check("R7 shift count rising only", nshift, 8);
        stop();
    endtask

    // R2: only half-period intervals, never locks
    task automatic t_no_lock();
        start(2'd0, 2'b11);
        for (int i = 0; i < 12; i++) man_bit(1'b1, 8);
        wait_clk(48);
        check("R2 no lock on half intervals", nshift, 0);
        stop();
    endtask

    // R7: all edges disabled
    task automatic t_edges_off();
        start(2'd0, 2'b00);
        man_pre(8);
        man_data(8'hA5, 8);
        wait_clk(48);
        check("R7 edges disabled", nshift, 0);
        stop();
    endtask

    // R3: no tick, no lock
    task automatic t_tick_off();
        tick_div = 0;
        start(2'd0, 2'b11);
        man_pre(8);
        man_data(8'h5A, 8);
        wait_clk(48);
        check("R3 tick held low", nshift, 0);
        stop();
        tick_div = 1;
    endtask

    // R2: stream while not armed
    task automatic t_disarmed();
        start(2'd0, 2'b11);
        arm = 1'b0;
        man_pre(8);
        man_data(8'hC3, 8);
        wait_clk(48);
        check("R2 disarmed", nshift, 0);
        check("R2 disarmed byte", nbyte, 0);
    endtask

    // R10: partial byte, gap, then a fresh byte
    task automatic t_timeout();
        start(2'd0, 2'b11);
        man_pre(8);
        man_bit(1'b1, 8); man_bit(1'b0, 8); man_bit(1'b1, 8); man_bit(1'b1, 8);
        wait_clk(60);
        man_pre(8);
        man_data(8'h5A, 8);
        wait_clk(48);
        check("R10 byte count after resync", nbyte, 1);
        check("R10 byte value after resync", int'(last_byte), 8'h5A);
        check("R10 total shifts", nshift, 14);
        stop();
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        arm = 1'b0;
        line_in = 1'b0;
        mode = 2'd0;
        edge_en = 2'b11;
        cmp_val = 8'd12;
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(2);
        // R1: reset state
        check("R1 data", int'(data_o), 0);
        check("R1 byte_rdy", int'(byte_rdy), 0);
        check("R1 shift_stb", int'(shift_stb), 0);
        check("R1 match_pulse", int'(match_pulse), 0);

        t_man(8'hA5, 1, "R4");
        t_man(8'hF0, 1, "R4 boundary");
        t_man(8'h3C, 2, "R3");
        t_bip(8'h96);
        t_bip(8'h0F);
        t_pw(8'hC5);
        t_no_lock();
        t_edges_off();
        t_tick_off();
        t_disarmed();
        t_timeout();

        summary();
        $finish;
    end

endmodule